// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the arithmetic and logic datapath of a small eight-bit processor core. A registered accumulator supplies one operand; the other arrives on the `operand` input. An operation code picks one of eleven functions. When the write enable is high at a rising clock edge, the result loads into the accumulator and a five-bit flag register is updated. The flag register holds sign, zero, nibble carry, even parity and carry/borrow.

The core sequencer applies an operation code and an operand with the write enable for one cycle. It reads back the accumulator and the flags on the next cycle. Multi-byte sums and differences are built by chaining the carry-using add and subtract codes byte by byte. Compare sets the flags as for a subtraction but keeps the accumulator, so it can feed conditional branches. Reset is synchronous and active high.

Flag layout on `flags_out`: bit 4 sign, bit 3 zero, bit 2 nibble carry, bit 1 parity, bit 0 carry.

Operation codes on `op`:
- 0 add
- 1 add with carry
- 2 subtract
- 3 subtract with borrow
- 4 compare
- 5 AND
- 6 OR
- 7 XOR
- 8 complement accumulator
- 9 increment operand
- 10 decrement operand
- 11 to 15 undefined

Top module: `alu8_acc`

## Requirements
- R1: When `rst` is high at a rising edge, the accumulator and all five flags become 0 on that edge.
- R2: When `we` is low at a rising edge, the accumulator and the flags keep their values.
- R3: Code 0 loads acc+operand and code 1 loads acc+operand+carry, both modulo 256. The carry flag (bit 0) becomes the carry out of bit 7.
- R4: Code 2 loads acc-operand and code 3 loads acc-operand-carry, both modulo 256. The carry flag becomes 1 exactly when the true difference is negative (borrow).
- R5: Code 4 leaves the accumulator unchanged. It sets all flags as code 2 would, so the carry flag is 1 exactly when acc < operand.
- R6: The nibble carry flag (bit 2) reflects the low four bits of each arithmetic operation. For addition it is the carry out of bit 3. For subtraction and compare it is 1 when acc[3:0] >= operand[3:0] + borrow-in, that is, when no borrow leaves the low nibble. For increment it is 1 when operand[3:0] is 15. For decrement it is 1 when operand[3:0] is nonzero.
- R7: After every defined code, the sign flag (bit 4) equals bit 7 of the result, and the zero flag (bit 3) is 1 exactly when the 8-bit result is 0.
- R8: After every defined code, the parity flag (bit 1) is 1 when the result has an even number of ones and 0 when it has an odd number.
- R9: Codes 5, 6 and 7 load acc AND, OR and XOR operand, and code 8 loads the bitwise complement of the accumulator. All four clear the carry flag and the nibble carry flag.
- R10: Code 9 loads operand+1 and code 10 loads operand-1, both modulo 256. Both leave the carry flag unchanged.
- R11: Codes 11 to 15 with `we` high change neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Update enable for accumulator and flags |
| op | input | 4 | Operation code |
| operand | input | 8 | Second operand |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 5 | Flags {sign, zero, nibble carry, parity, carry} |

## Verification
The hardest states to reach from the ports are the borrow-chained ones. Code 3 and code 1 depend on a carry flag left behind by an earlier operation, and the nibble carry for subtraction changes only when the low nibbles sit exactly at the borrow boundary. Directed sequences first set the carry with a wrapping add or subtract and then chain through it. Long random runs follow, with every code, sparse resets and dropped enables, and all of them are compared each cycle against a behavioural model. That model computes the nibble borrow as a plain comparison of low nibbles rather than as an addition.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_STEP  = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    LSEL_AND = 2'd0,
    LSEL_OR  = 2'd1,
    LSEL_XOR = 2'd2,
    LSEL_NOT = 2'd3
  } logic_sel_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

  typedef struct packed {
    logic       valid;
    op_class_e  cls;
    logic       sub;
    logic       chain;
    logic       write_acc;
    logic       step_down;
    logic_sel_e lsel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output alu_ctrl_t        ctrl
);

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  always_comb begin
    ctrl           = '0;
    ctrl.cls       = CLS_ARITH;
    ctrl.lsel      = LSEL_AND;
    ctrl.write_acc = 1'b1;
    ctrl.valid     = 1'b1;
    case (op_e)
      OP_ADD: ;
      OP_ADC: ctrl.chain = 1'b1;
      OP_SUB: ctrl.sub = 1'b1;
      OP_SBB: begin
        ctrl.sub   = 1'b1;
        ctrl.chain = 1'b1;
      end
      OP_CMP: begin
        ctrl.sub       = 1'b1;
        ctrl.write_acc = 1'b0;
      end
      OP_AND: ctrl.cls = CLS_LOGIC;
      OP_OR: begin
        ctrl.cls  = CLS_LOGIC;
        ctrl.lsel = LSEL_OR;
      end
      OP_XOR: begin
        ctrl.cls  = CLS_LOGIC;
        ctrl.lsel = LSEL_XOR;
      end
      OP_NOT: begin
        ctrl.cls  = CLS_LOGIC;
        ctrl.lsel = LSEL_NOT;
      end
      OP_INC: ctrl.cls = CLS_STEP;
      OP_DEC: begin
        ctrl.cls       = CLS_STEP;
        ctrl.step_down = 1'b1;
      end
      default: begin
        ctrl.valid     = 1'b0;
        ctrl.write_acc = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             half_carry,
  output logic             carry_out
);

  localparam int NIB_W = 4;
  localparam int NIBS  = WIDTH / NIB_W;

  logic [NIBS:0] chain_c;
  assign chain_c[0] = cin;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIB_W:0] part;
    assign part = {1'b0, a[g*NIB_W +: NIB_W]}
                + {1'b0, b[g*NIB_W +: NIB_W]}
                + {{NIB_W{1'b0}}, chain_c[g]};
    assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
    assign chain_c[g+1]          = part[NIB_W];
  end

  assign half_carry = chain_c[1];
  assign carry_out  = chain_c[NIBS];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic_sel_e       sel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    case (sel)
      LSEL_AND: y = a & b;
      LSEL_OR:  y = a | b;
      LSEL_XOR: y = a ^ b;
      default:  y = ~a;
    endcase
  end

endmodule

// File: rtl/alu8_acc.sv
module alu8_acc
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] acc_out,
  output logic [4:0]       flags_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  function automatic logic f_even_par(input logic [WIDTH-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic f_is_zero(input logic [WIDTH-1:0] v);
    return (v == '0);
  endfunction

  alu_ctrl_t   ctrl;
  alu_flags_t  flags_q;
  alu_flags_t  flags_d;
  logic [WIDTH-1:0] add_a, add_b, add_sum, log_y, result;
  logic        add_cin, add_hc, add_co;
  logic        upd_fire, acc_load;

  alu8_decode u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  always_comb begin
    if (ctrl.cls == CLS_STEP) begin
      add_a   = operand;
      add_b   = ctrl.step_down ? ALL_ONES : '0;
      add_cin = ~ctrl.step_down;
    end else begin
      add_a   = acc_out;
      add_b   = ctrl.sub ? ~operand : operand;
      if (ctrl.sub) add_cin = ctrl.chain ? ~flags_q.cy : 1'b1;
      else          add_cin = ctrl.chain ?  flags_q.cy : 1'b0;
    end
  end

  alu8_adder #(.WIDTH(WIDTH)) u_add (
    .a          (add_a),
    .b          (add_b),
    .cin        (add_cin),
    .sum        (add_sum),
    .half_carry (add_hc),
    .carry_out  (add_co)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_log (
    .sel (ctrl.lsel),
    .a   (acc_out),
    .b   (operand),
    .y   (log_y)
  );

  always_comb begin
    result     = (ctrl.cls == CLS_LOGIC) ? log_y : add_sum;
    flags_d.s  = result[WIDTH-1];
    flags_d.z  = f_is_zero(result);
    flags_d.p  = f_even_par(result);
    case (ctrl.cls)
      CLS_ARITH: begin
        flags_d.ac = add_hc;
        flags_d.cy = ctrl.sub ? ~add_co : add_co;
      end
      CLS_STEP: begin
        flags_d.ac = add_hc;
        flags_d.cy = flags_q.cy;
      end
      default: begin
        flags_d.ac = 1'b0;
        flags_d.cy = 1'b0;
      end
    endcase
  end

  assign upd_fire = we && ctrl.valid;
  assign acc_load = upd_fire && ctrl.write_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      flags_q <= '0;
    end else if (upd_fire) begin
      if (ctrl.write_acc) acc_out <= result;
      flags_q <= flags_d;
    end
  end

  assign flags_out = flags_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && flags_q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(acc_out) && $stable(flags_q)));

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_CMP) |=> $stable(acc_out));

  assert_zero_sign_R7: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> (flags_q.z == (acc_out == '0) && flags_q.s == acc_out[WIDTH-1]));

  assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> (flags_q.p == ~(^acc_out)));

  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (we && ctrl.valid && ctrl.cls == CLS_LOGIC) |=> (!flags_q.cy && !flags_q.ac));

  assert_step_keeps_cy_R10: assert property (@(posedge clk) disable iff (rst)
    (we && (op == OP_INC || op == OP_DEC)) |=> (flags_q.cy == $past(flags_q.cy)));

  assert_undef_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (we && op > OP_DEC) |=> ($stable(acc_out) && $stable(flags_q)));

endmodule

// File: tb/alu8_acc_tb.sv
module alu8_acc_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_out;
  logic [4:0] flags_out;

  always #5 clk = ~clk;

  alu8_acc u_dut (
    .clk       (clk),
    .rst       (rst),
    .we        (we),
    .op        (op),
    .operand   (operand),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  int m_acc = 0, m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;
  int n_cmp = 0, n_bad = 0;

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) % 2 == 1) c++;
    return c;
  endfunction

  function automatic string tag_of(input logic r, input logic w, input int o);
    if (r) return "R1";
    if (!w) return "R2";
    if (o <= 1) return "R3,R6,R7,R8";
    if (o <= 3) return "R4,R6,R7,R8";
    if (o == 4) return "R5,R6,R8";
    if (o <= 8) return "R9,R7,R8";
    if (o <= 10) return "R10,R6,R7,R8";
    return "R11";
  endfunction

  task automatic model(input logic r, input logic w, input int o, input int b);
    int res = 0, t, cin, wr = 1;
    if (r) begin
      m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
      return;
    end
    if (!w || o > 10) return;
    case (o)
      0, 1: begin
        cin  = (o == 1) ? m_cy : 0;
        t    = m_acc + b + cin;
        m_ac = ((m_acc % 16) + (b % 16) + cin > 15) ? 1 : 0;
        m_cy = (t > 255) ? 1 : 0;
        res  = t % 256;
      end
      2, 3, 4: begin
        cin  = (o == 3) ? m_cy : 0;
        t    = m_acc - b - cin;
        m_ac = ((m_acc % 16) >= (b % 16) + cin) ? 1 : 0;
        m_cy = (t < 0) ? 1 : 0;
        res  = (t + 256) % 256;
        wr   = (o != 4) ? 1 : 0;
      end
      5: begin res = m_acc & b; m_cy = 0; m_ac = 0; end
      6: begin res = m_acc | b; m_cy = 0; m_ac = 0; end
      7: begin res = m_acc ^ b; m_cy = 0; m_ac = 0; end
      8: begin res = 255 - m_acc; m_cy = 0; m_ac = 0; end
      9: begin res = (b + 1) % 256; m_ac = (b % 16 == 15) ? 1 : 0; end
      default: begin res = (b + 255) % 256; m_ac = (b % 16 != 0) ? 1 : 0; end
    endcase
    m_s = (res >= 128) ? 1 : 0;
    m_z = (res == 0) ? 1 : 0;
    m_p = (ones(res) % 2 == 0) ? 1 : 0;
    if (wr == 1) m_acc = res;
  endtask

  task automatic cycle(input logic r, input logic w, input int o, input int b, input string tag);
    logic [4:0] ef;
    rst = r; we = w; op = o[3:0]; operand = b[7:0];
    model(r, w, o, b);
    @(negedge clk);
    ef = {m_s[0], m_z[0], m_ac[0], m_p[0], m_cy[0]};
    n_cmp++;
    if (acc_out !== m_acc[7:0] || flags_out !== ef) begin
      n_bad++;
      $display("FAIL %s op=%0d b=%02h: acc=%02h flags=%05b expected acc=%02h flags=%05b",
               tag, o, b, acc_out, flags_out, m_acc[7:0], ef);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cycle(1, 0, 0, 0, "R1");
    cycle(1, 1, 0, 8'h55, "R1");
    cycle(0, 1, 0, 8'h3F, "R3");       // acc 3F
    cycle(0, 1, 0, 8'hC1, "R3,R6,R7"); // wraps to 00, carry, nibble carry, zero
    cycle(0, 1, 1, 8'h05, "R3");       // 0+5+1 = 06
    cycle(0, 1, 2, 8'h07, "R4,R6");    // 06-07 = FF, borrow
    cycle(0, 1, 3, 8'h00, "R4");       // FF-0-1 = FE
    cycle(0, 1, 3, 8'h0E, "R4,R6");    // F0, nibble equal boundary
    cycle(0, 1, 4, 8'hF1, "R5");       // F0 < F1: borrow, acc stays
    cycle(0, 1, 4, 8'h10, "R5,R6");
    cycle(0, 1, 5, 8'h3C, "R9");
    cycle(0, 1, 8, 8'h00, "R9,R8");
    cycle(0, 1, 6, 8'h01, "R9");
    cycle(0, 1, 7, 8'hFF, "R9");
    cycle(0, 1, 2, 8'hFF, "R4");       // set borrow
    cycle(0, 1, 9, 8'h0F, "R10,R6");   // carry must survive
    cycle(0, 1, 10, 8'h00, "R10,R6");
    cycle(0, 1, 9, 8'hFF, "R10,R7");
    cycle(0, 0, 0, 8'h11, "R2");
    cycle(0, 1, 12, 8'h22, "R11");
    cycle(0, 1, 15, 8'h00, "R11");
    cycle(1, 1, 11, 8'h00, "R1");
    for (int i = 0; i < 6000; i++) begin
      logic r, w;
      int o, b;
      r = ($urandom % 64) == 0;
      w = ($urandom % 8) != 0;
      o = $urandom % 16;
      b = $urandom % 256;
      if (i % 5 == 0) b = (b & 8'hF0) | (m_acc & 8'h0F);
      cycle(r, w, o, b, tag_of(r, w, o));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule